// File: doc/BRIEF.md
# Zero-Crossing Synchronized Stereo Volume Controller

This block is a two-channel digital gain stage for signed PCM audio. Left and right samples arrive together under one valid strobe; each channel is scaled by its own volume code and the scaled pair leaves one clock later. Balance is set by giving the two channels different codes. A small register-write port sets the two volume codes and a control word holding a general mute bit, a zero-crossing mode bit and a mute timing bit.

The point of the block is click-free gain changes. With zero-crossing mode on, a written volume is held as pending for that channel and only replaces the active gain on a sample where that channel's signal crosses zero. A change to the mute code bypasses the wait. The general mute has its own timing choice: applied at once, or carried out per channel at that channel's next zero crossing.

Top module: `zc_volume_ctrl`

## Requirements
- R1: After reset, out_valid is 0, both outputs are 0, both channels hold the mute code with nothing pending, and the general mute, zero-crossing mode and mute timing bits are 0; samples give zero output until a volume is written.
- R2: Register addresses: 0 = left volume code, 1 = right volume code, 2 = control (bit 0 general mute, bit 1 zero-crossing mode, bit 2 mute timing). A volume code n in 0..87 means a gain of (16 - n) dB; any code of 88 or above is mute and gives output 0.
- R3: For code n below 88, with a = n + 2, the output is floor(x * 8 * T[a mod 6] / 2^(14 + a div 6)) where T = {16384, 14604, 13014, 11599, 10338, 9213}.
- R4: Each valid input pair produces out_valid high and the scaled pair exactly one cycle later; without a valid input, out_valid is 0 and the output data holds its last value.
- R5: A channel sees a zero crossing on a valid sample that is exactly 0 or whose sign bit differs from that channel's previous valid sample (taken as non-negative after reset).
- R6: With zero-crossing mode off, a volume write takes effect from the next valid sample.
- R7: With zero-crossing mode on, a volume write becomes pending and the pending code scales the first later valid sample of that channel that is a zero crossing, then becomes the active code.
- R8: With zero-crossing mode on, a volume write while a value is already pending makes the earlier pending code active at once and the new code pending.
- R9: A write of a mute code (88 or above) takes effect from the next valid sample in either mode and discards any pending code.
- R10: With mute timing 0, the general mute bit silences or releases both outputs from the next valid sample after the control write.
- R11: With mute timing 1, a change of the general mute bit takes effect for each channel at that channel's next zero-crossing sample (that sample included), independently per channel.
- R12: Left and right codes, pending state and zero-crossing detection are independent: a write to one channel never changes the other channel's output.
- R13: Scaled results beyond the signed output range saturate to the largest positive or most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CODE_W | Register write data |
| in_valid | input | 1 | Input sample pair valid |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| out_valid | output | 1 | Output sample pair valid |
| out_left | output | DATA_W | Left output sample, signed |
| out_right | output | DATA_W | Right output sample, signed |

## Verification
The hardest state to reach is a channel holding a pending code across several writes while its signal refuses to cross zero, with the other channel crossing meanwhile and a timed general mute armed at the same time. The stimulus produces it with long runs of same-signed samples on one channel and alternating signs on the other, interleaving volume and control writes between them, and then a long mixed phase where writes, mode changes and sign runs are drawn at random against the behavioural model.

// File: rtl/zcv_pkg.sv
// Shared constants and the fractional gain table for the volume controller.
// Assumes gain fractions are unsigned Q2.14 values below 1.0 dB steps.
package zcv_pkg;
    localparam int GAIN_FRAC_W = 14;   // fraction bits of the table entries
    localparam int HEADROOM_SH = 3;    // +18 dB pre-scale (x8) before shifting
    localparam int CODE_OFFSET = 2;    // code offset so that +18 dB maps to index 0
    localparam int DB_PER_SHIFT = 6;   // one binary shift per 6 dB

    localparam logic [1:0] ADDR_VOL_L = 2'd0;
    localparam logic [1:0] ADDR_VOL_R = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    localparam int CTRL_GMUTE  = 0;
    localparam int CTRL_ZCMODE = 1;
    localparam int CTRL_MTIME  = 2;

    // Attenuation of 0..5 dB expressed as a Q14 multiplier.
    function automatic logic [15:0] frac_gain(input logic [2:0] rem);
        case (rem)
            3'd0:    frac_gain = 16'd16384;
            3'd1:    frac_gain = 16'd14604;
            3'd2:    frac_gain = 16'd13014;
            3'd3:    frac_gain = 16'd11599;
            3'd4:    frac_gain = 16'd10338;
            default: frac_gain = 16'd9213;
        endcase
    endfunction
endpackage

// File: rtl/zcv_zero_detect.sv
// Per-channel zero-crossing detector.
// Flags a valid sample that is exactly zero or whose sign differs from the
// previous valid sample; the remembered sign starts non-negative at reset.
module zcv_zero_detect #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] sample,
    output logic              zc
);
    logic prev_neg;

    // Crossing flag for the current sample, qualified by valid.
    always_comb begin
        zc = valid && ((sample == '0) || (sample[DATA_W-1] != prev_neg));
    end

    // Remember the sign of the last valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)     prev_neg <= 1'b0;
        else if (valid) prev_neg <= sample[DATA_W-1];
    end
endmodule

// File: rtl/zcv_vol_channel.sv
// Per-channel volume state: active code, pending code and timed mute flag.
// Decides which code and mute state apply to the sample in this cycle.
// Assumes zc is already qualified with the sample valid strobe.
module zcv_vol_channel #(
    parameter int CODE_W    = 8,
    parameter int MUTE_CODE = 88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              zc_mode,
    input  logic              mute_timing,
    input  logic              gmute,
    input  logic              zc,
    output logic [CODE_W-1:0] eff_code,
    output logic              eff_mute
);
    localparam logic [CODE_W-1:0] MUTE_C = CODE_W'(MUTE_CODE);

    logic [CODE_W-1:0] cur_code;
    logic [CODE_W-1:0] pend_code;
    logic              pend_v;
    logic              mute_flag;
    logic              wr_is_mute;

    // Code and mute seen by the current sample.
    always_comb begin
        wr_is_mute = (wr_code >= MUTE_C);
        eff_code   = (zc && pend_v) ? pend_code : cur_code;
        eff_mute   = mute_timing ? (zc ? gmute : mute_flag) : gmute;
    end

    // Volume update: writes take priority over a crossing commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_code  <= MUTE_C;
            pend_code <= MUTE_C;
            pend_v    <= 1'b0;
        end else if (wr_hit) begin
            if (!zc_mode || wr_is_mute) begin
                cur_code <= wr_code;
                pend_v   <= 1'b0;
            end else begin
                if (pend_v) cur_code <= pend_code;
                pend_code <= wr_code;
                pend_v    <= 1'b1;
            end
        end else if (zc && pend_v) begin
            cur_code <= pend_code;
            pend_v   <= 1'b0;
        end
    end

    // Channel mute follows general mute at once or at a crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mute_flag <= 1'b0;
        else if (!mute_timing || zc) mute_flag <= gmute;
    end
endmodule

// File: rtl/zcv_scaler.sv
// Combinational gain: x8 pre-scale, Q14 fraction for the dB remainder,
// arithmetic right shift per 6 dB, then saturation to the sample width.
// Mute or a mute code forces zero.
module zcv_scaler #(
    parameter int DATA_W    = 16,
    parameter int CODE_W    = 8,
    parameter int MUTE_CODE = 88
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [CODE_W-1:0] code,
    input  logic              mute,
    output logic [DATA_W-1:0] result
);
    import zcv_pkg::*;

    localparam int PW = DATA_W + 16 + HEADROOM_SH + 1;
    localparam logic signed [PW-1:0] MAX_V = PW'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [PW-1:0] MIN_V = -PW'(64'sd1 <<< (DATA_W - 1));
    localparam logic [CODE_W-1:0] MUTE_C = CODE_W'(MUTE_CODE);

    logic [CODE_W:0]        att;
    logic [2:0]             rem;
    logic [CODE_W:0]        shf;
    logic signed [PW-1:0]   xs;
    logic signed [PW-1:0]   gs;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   shifted;

    // Split the attenuation into a shift count and a fractional index.
    always_comb begin
        att = {1'b0, code} + (CODE_W + 1)'(CODE_OFFSET);
        rem = 3'(att % (CODE_W + 1)'(DB_PER_SHIFT));
        shf = att / (CODE_W + 1)'(DB_PER_SHIFT);
    end

    // Multiply, shift down and saturate.
    always_comb begin
        xs      = {{(PW - DATA_W){sample[DATA_W-1]}}, sample};
        gs      = {{(PW - 16){1'b0}}, frac_gain(rem)};
        prod    = (xs * gs) <<< HEADROOM_SH;
        shifted = prod >>> (shf + (CODE_W + 1)'(GAIN_FRAC_W));
        if (mute || (code >= MUTE_C)) result = '0;
        else if (shifted > MAX_V)     result = MAX_V[DATA_W-1:0];
        else if (shifted < MIN_V)     result = MIN_V[DATA_W-1:0];
        else                          result = shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/zc_volume_ctrl.sv
// Stereo volume controller with zero-crossing synchronized gain and mute.
// Holds the control register, instantiates one detector, state channel and
// scaler per side, and registers the scaled pair one cycle after the input.
module zc_volume_ctrl #(
    parameter int DATA_W    = 16,
    parameter int CODE_W    = 8,
    parameter int MUTE_CODE = 88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    import zcv_pkg::*;

    localparam int NCH = 2;

    logic              gmute_q;
    logic              zcmode_q;
    logic              mtime_q;
    logic [DATA_W-1:0] smp    [NCH];
    logic [DATA_W-1:0] scaled [NCH];

    assign smp[0] = in_left;
    assign smp[1] = in_right;

    // Control register: general mute, zero-crossing mode, mute timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmute_q  <= 1'b0;
            zcmode_q <= 1'b0;
            mtime_q  <= 1'b0;
        end else if (wr_en && (wr_addr == ADDR_CTRL)) begin
            gmute_q  <= wr_data[CTRL_GMUTE];
            zcmode_q <= wr_data[CTRL_ZCMODE];
            mtime_q  <= wr_data[CTRL_MTIME];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic              zc;
        logic [CODE_W-1:0] code;
        logic              mute;

        zcv_zero_detect #(.DATA_W(DATA_W)) u_zd (
            .clk(clk), .rst_n(rst_n), .valid(in_valid),
            .sample(smp[ch]), .zc(zc)
        );

        zcv_vol_channel #(.CODE_W(CODE_W), .MUTE_CODE(MUTE_CODE)) u_vc (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(wr_en && (wr_addr == 2'(ch))),
            .wr_code(wr_data), .zc_mode(zcmode_q),
            .mute_timing(mtime_q), .gmute(gmute_q), .zc(zc),
            .eff_code(code), .eff_mute(mute)
        );

        zcv_scaler #(.DATA_W(DATA_W), .CODE_W(CODE_W), .MUTE_CODE(MUTE_CODE)) u_sc (
            .sample(smp[ch]), .code(code), .mute(mute), .result(scaled[ch])
        );
    end

    // Output register: capture the scaled pair on each valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= scaled[0];
                out_right <= scaled[1];
            end
        end
    end
endmodule

// File: rtl/zcv_checker.sv
// Port-level properties of the volume controller, bound to its top module.
module zcv_checker #(
    parameter int DATA_W    = 16,
    parameter int CODE_W    = 8,
    parameter int MUTE_CODE = 88
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [CODE_W-1:0] wr_data,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_left,
    input logic [DATA_W-1:0] in_right,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right
);
    // R4: out_valid follows the input strobe one cycle later.
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R4: without a valid input the output data holds.
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));

    // R3: positive gain keeps the sign of a nonzero result.
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_left != '0) |->
            (out_left[DATA_W-1] == $past(in_left[DATA_W-1])));

    // R9: a mute code on the left silences the next sample.
    a_r9_mute_code_now: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data >= CODE_W'(MUTE_CODE)) ##1 in_valid
            |=> (out_left == '0));

    // R10: immediate general mute silences both outputs on the next sample.
    a_r10_gmute_now: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && wr_data[0] && !wr_data[2]) ##1 in_valid
            |=> (out_left == '0 && out_right == '0));

    // R12: a right-channel sample pair with a zero left input gives zero left.
    a_r12_left_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_left == '0) |=> (out_left == '0));

    // Keeps the right-side inputs referenced for completeness.
    a_r4_right_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_right == '0) |=> (out_right == '0));
endmodule

bind zc_volume_ctrl zcv_checker #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .MUTE_CODE(MUTE_CODE)
) u_zcv_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right)
);

// File: tb/test_zc_volume_ctrl.sv
// Bench with a behavioural reference model compared on every clock.
module test_zc_volume_ctrl;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int MUTEC = 88;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_left = '0;
    logic [DW-1:0] in_right = '0;
    logic out_valid;
    logic [DW-1:0] out_left;
    logic [DW-1:0] out_right;

    always #5 clk = ~clk;

    zc_volume_ctrl #(.DATA_W(DW), .CODE_W(CW), .MUTE_CODE(MUTEC)) i_zc_volume_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right)
    );

    int checks = 0;
    int failures = 0;
    bit compare_on = 0;
    bit done = 0;
    string cur_req = "R1";

    // Reference model state
    int m_cur[2], m_pend[2], m_neg[2];
    bit m_pv[2], m_mf[2];
    bit m_gm, m_zm, m_tm;
    int e_l, e_r;
    bit e_v;
    int tab[6] = '{16384, 14604, 13014, 11599, 10338, 9213};

    function automatic int ref_scale(int x, int code, bit mute);
        longint p;
        int a;
        if (mute || code >= MUTEC) return 0;
        a = code + 2;
        p = longint'(x) * tab[a % 6] * 8;
        p = p >>> (14 + a / 6);
        if (p > 32767) return 32767;
        if (p < -32768) return -32768;
        return int'(p);
    endfunction

    // Model: compute the expected output, then update its state.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_cur[c] = MUTEC; m_pend[c] = MUTEC; m_pv[c] = 0; m_mf[c] = 0; m_neg[c] = 0;
            end
            m_gm = 0; m_zm = 0; m_tm = 0; e_v = 0; e_l = 0; e_r = 0;
        end else begin
            int x[2];
            bit zc[2];
            int res[2];
            x[0] = int'($signed(in_left));
            x[1] = int'($signed(in_right));
            for (int c = 0; c < 2; c++) begin
                int code;
                bit mu;
                zc[c] = in_valid && (x[c] == 0 || (x[c] < 0) != (m_neg[c] != 0));
                code = (zc[c] && m_pv[c]) ? m_pend[c] : m_cur[c];
                mu = m_tm ? (zc[c] ? m_gm : m_mf[c]) : m_gm;
                res[c] = ref_scale(x[c], code, mu);
            end
            e_v = in_valid;
            if (in_valid) begin e_l = res[0]; e_r = res[1]; end
            for (int c = 0; c < 2; c++) begin
                if (wr_en && wr_addr == 2'(c)) begin
                    int w;
                    w = int'(wr_data);
                    if (!m_zm || w >= MUTEC) begin m_cur[c] = w; m_pv[c] = 0; end
                    else begin
                        if (m_pv[c]) m_cur[c] = m_pend[c];
                        m_pend[c] = w; m_pv[c] = 1;
                    end
                end else if (zc[c] && m_pv[c]) begin
                    m_cur[c] = m_pend[c]; m_pv[c] = 0;
                end
                if (!m_tm || zc[c]) m_mf[c] = m_gm;
                if (in_valid) m_neg[c] = (x[c] < 0);
            end
            if (wr_en && wr_addr == 2'd2) begin
                m_gm = wr_data[0]; m_zm = wr_data[1]; m_tm = wr_data[2];
            end
        end
    end

    // Compare DUT with the model every clock, away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            checks++;
            if (out_valid !== e_v || int'($signed(out_left)) != e_l ||
                int'($signed(out_right)) != e_r) begin
                failures++;
                $display("FAIL %s model: act v=%0b l=%0d r=%0d exp v=%0b l=%0d r=%0d",
                         cur_req, out_valid, $signed(out_left), $signed(out_right), e_v, e_l, e_r);
            end
        end
    end

    task automatic check_val(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus, driven at the falling edge.
    task automatic cyc(bit v, int l, int r, bit w = 0, int a = 0, int d = 0);
        @(negedge clk);
        in_valid = v; in_left = DW'(l); in_right = DW'(r);
        wr_en = w; wr_addr = 2'(a); wr_data = CW'(d);
    endtask

    task automatic wr(int a, int d);
        cyc(0, 0, 0, 1, a, d);
    endtask

    // Drive one sample and read back the result one cycle later.
    task automatic sample_chk(string req, int l, int r, int el, int er);
        cyc(1, l, r);
        cyc(0, 0, 0);
        #1;
        check_val(req, int'($signed(out_left)), el);
        check_val(req, int'($signed(out_right)), er);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state at the ports
        #1;
        check_val("R1", int'(out_valid), 0);
        check_val("R1", int'($signed(out_left)), 0);
        compare_on = 1;
        cur_req = "R1";
        sample_chk("R1", 1000, -1000, 0, 0);

        // R2/R3: 0 dB code 16 passes the sample unchanged
        cur_req = "R3";
        wr(0, 16); wr(1, 16);
        sample_chk("R3", 1000, -1234, 1000, -1234);
        // R2: code 22 is -6 dB, halves the sample
        wr(0, 22);
        sample_chk("R2", 1000, 50, 500, 50);
        // R13: +16 dB saturates
        cur_req = "R13";
        wr(0, 0); wr(1, 0);
        sample_chk("R13", 20000, -20000, 32767, -32768);
        // R2: mute code 88 and above
        cur_req = "R2";
        wr(0, 88); wr(1, 200);
        sample_chk("R2", 5000, 5000, 0, 0);

        // R6/R3: random codes and samples with zero-crossing mode off
        cur_req = "R6";
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) == 0) cyc(0, 0, 0, 1, $urandom_range(0, 1), $urandom_range(0, 95));
            else cyc(1, int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768);
        end
        // R4: idle cycles hold the data
        cur_req = "R4";
        repeat (4) cyc(0, 123, 456);

        // R7: zero-crossing mode, pending until a crossing
        cur_req = "R7";
        wr(0, 16); wr(1, 16);
        cyc(1, 100, 100);
        wr(2, 2);
        wr(0, 22);
        sample_chk("R7", 400, 400, 400, 400);   // no crossing: old code
        sample_chk("R7", -400, 400, -200, 400); // crossing left: new code applies
        sample_chk("R7", -600, 400, -300, 400);
        // R8: second write commits the earlier pending value
        cur_req = "R8";
        wr(0, 16);
        wr(0, 28);
        sample_chk("R8", -800, 400, -800, 400); // 16 active, 28 pending
        sample_chk("R8", 800, 400, 200, 400);   // crossing: -12 dB
        // R9: mute code immediate, pending discarded
        cur_req = "R9";
        wr(0, 16);
        wr(0, 90);
        sample_chk("R9", 800, 400, 0, 0 + 400);
        sample_chk("R9", -800, 400, 0, 400);
        // R12: right unaffected by left writes, own pending
        cur_req = "R12";
        wr(1, 22);
        sample_chk("R12", -800, 400, 0, 400);
        sample_chk("R12", 800, 0, 0, 0);
        sample_chk("R12", 800, 400, 0, 200);

        // R10: immediate general mute
        cur_req = "R10";
        wr(0, 16);
        sample_chk("R10", 0, 400, 0, 200);
        wr(2, 1);
        sample_chk("R10", 300, 400, 0, 0);
        wr(2, 0);
        sample_chk("R10", 300, 400, 300, 200);
        // R11: timed mute waits per channel
        cur_req = "R11";
        wr(2, 5);
        sample_chk("R11", 300, 400, 300, 200);
        sample_chk("R11", -300, 400, 0, 200);
        sample_chk("R11", -300, -400, 0, 0);
        wr(2, 4);
        sample_chk("R11", -300, -400, 0, 0);
        sample_chk("R11", 300, -400, 300, 0);

        // R5/R7/R8/R11: long mixed run with sign runs and random writes
        cur_req = "R5";
        begin
            int sl = 1, sr = 1;
            for (int i = 0; i < 3000; i++) begin
                int k;
                k = $urandom_range(0, 9);
                if ($urandom_range(0, 5) == 0) sl = -sl;
                if ($urandom_range(0, 2) == 0) sr = -sr;
                if (k == 0) cyc(0, 0, 0, 1, $urandom_range(0, 1), $urandom_range(0, 92));
                else if (k == 1) cyc(1, sl * int'($urandom_range(0, 32767)), sr * 7, 1, 2, $urandom_range(0, 7));
                else if (k == 2) cyc(1, 0, sr * 9000, 1, $urandom_range(0, 1), $urandom_range(0, 40));
                else cyc(k != 3, sl * int'($urandom_range(0, 32767)), sr * int'($urandom_range(0, 32767)));
            end
        end
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        compare_on = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule